// File: doc/BRIEF.md
# Selectable Reference Divider Chain

This block turns one fast oscillator clock (nominally 4 MHz) into a set of slower timing outputs for a frequency synthesizer. The stages are cascaded, and each one advances only when the stage before it fires. The chain produces four taps:

- a 500 kHz tap for an external controller, given both as a one-cycle strobe and as a 50% duty square wave;
- a 12.5 kHz tuning reference;
- a 500 Hz tuning reference;
- a 50 Hz time-of-day tick.

All strobes are one input-clock cycle wide and live in the input clock domain.

A band-select input picks which tuning reference is forwarded to the phase comparator: the 12.5 kHz tap for the FM band, or the 500 Hz tap for the AM band. The block only takes up a new band value at a 500 Hz boundary. Every 500 Hz strobe coincides with a 12.5 kHz strobe, so a band change never produces a shortened reference period. The band in force is visible on its own output.

There is no data stream at the edge of the block. Every pin is a plain control or timing signal, and there is no handshake or back-pressure.

Top module: `refdiv_top`

## Requirements
- R1: While `rst` is high at a rising edge, every stage counter clears to zero. During reset all strobe outputs are 0, `ctrl_sq` is 1, and `band_active` takes the value of `band_sel`.
- R2: Let k be the number of rising edges since `rst` went low. `tick_ctrl` is 1 exactly when k mod 8 equals 7.
- R3: `ctrl_sq` is 1 when k mod 8 is 0 to 3 and 0 when it is 4 to 7. This gives a 50% duty square wave that rises in the cycle after each `tick_ctrl`.
- R4: `tick_fm` is 1 exactly when k mod 320 equals 319.
- R5: `tick_am` is 1 exactly when k mod 8000 equals 7999.
- R6: `tick_tod` is 1 exactly when k mod 80000 equals 79999, and it is always accompanied by `tick_am`.
- R7: `ref_tick` equals `tick_fm` while `band_active` is 1 (FM) and equals `tick_am` while `band_active` is 0 (AM).
- R8: `band_active` loads `band_sel` only at a rising edge where `tick_am` is 1. Changes of `band_sel` at any other edge are ignored, and `band_active` holds.
- R9: Reset applied in the middle of a run restarts every tap phase from k = 0, so the first `tick_ctrl` after release comes on the 8th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock driving the whole chain |
| rst | input | 1 | Synchronous reset, active high |
| band_sel | input | 1 | Requested band: 1 = FM (12.5 kHz reference), 0 = AM (500 Hz reference) |
| ctrl_sq | output | 1 | 500 kHz square wave, 50% duty |
| tick_ctrl | output | 1 | 500 kHz one-cycle strobe |
| tick_fm | output | 1 | 12.5 kHz one-cycle strobe |
| tick_am | output | 1 | 500 Hz one-cycle strobe |
| tick_tod | output | 1 | 50 Hz one-cycle time-of-day strobe |
| ref_tick | output | 1 | Reference strobe forwarded to the phase comparator |
| band_active | output | 1 | Band currently applied to `ref_tick` |

## Verification
The bench changes `band_sel` well inside a 500 Hz period, pulses it and returns it before a boundary, and changes it on the very cycle before a boundary. Together these expose a selector that switches early, which would shorten the reference period, or one that misses the boundary edge by a cycle. The bench runs past two 50 Hz periods, so an off-by-one ratio in any stage, or a wrap at the wrong count, shifts a strobe and shows up against the model. A reset in mid-run at an odd phase checks that no stage keeps a stale count. The square-wave phase is compared on every cycle, which catches an inverted or skewed duty.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int unsigned NUM_TAPS = 4;
  localparam int unsigned TAP_CTRL = 0;
  localparam int unsigned TAP_FM   = 1;
  localparam int unsigned TAP_AM   = 2;
  localparam int unsigned TAP_TOD  = 3;

  typedef enum logic {
    BAND_AM = 1'b0,
    BAND_FM = 1'b1
  } band_e;
endpackage

// File: rtl/refdiv_prescale.sv
module refdiv_prescale #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic sq
);
  localparam int unsigned W    = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);
  localparam logic [W-1:0] HALF = W'(DIV / 2);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = (cnt == LAST);
  assign sq   = (cnt < HALF);

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R2
  AST_SQ_RISE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    tick |=> sq); // R3
  AST_SQ_LOW_AT_TICK: assert property (@(posedge clk) disable iff (rst)
    tick |-> !sq); // R3
endmodule

// File: rtl/refdiv_stage.sv
module refdiv_stage #(
  parameter int unsigned DIV = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic en_in,
  output logic en_out
);
  localparam int unsigned W    = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (en_in) begin
      if (cnt == LAST) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign en_out = en_in && (cnt == LAST);

  AST_STG_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R4
  AST_STG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en_in |=> $stable(cnt)); // R5
  AST_STG_ONLY_ON_EN: assert property (@(posedge clk) disable iff (rst)
    en_out |-> en_in); // R6
endmodule

// File: rtl/refdiv_refsel.sv
module refdiv_refsel
  import refdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic band_sel,
  input  logic tick_fm,
  input  logic tick_am,
  output logic ref_tick,
  output logic band_active
);
  band_e band_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      band_q <= band_e'(band_sel);
    end else if (tick_am) begin
      band_q <= band_e'(band_sel);
    end
  end

  assign ref_tick    = (band_q == BAND_FM) ? tick_fm : tick_am;
  assign band_active = band_q;

  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_am |=> $stable(band_q)); // R8
  AST_REF_ON_FM_TAP: assert property (@(posedge clk) disable iff (rst)
    ref_tick |-> tick_fm); // R7
  AST_AM_QUIET: assert property (@(posedge clk) disable iff (rst)
    (band_q == BAND_AM && tick_fm && !tick_am) |-> !ref_tick); // R7
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int unsigned RATIO_CTRL = 8,
  parameter int unsigned RATIO_FM   = 40,
  parameter int unsigned RATIO_AM   = 25,
  parameter int unsigned RATIO_TOD  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic band_sel,
  output logic ctrl_sq,
  output logic tick_ctrl,
  output logic tick_fm,
  output logic tick_am,
  output logic tick_tod,
  output logic ref_tick,
  output logic band_active
);
  localparam int unsigned RATIO [NUM_TAPS] = '{RATIO_CTRL, RATIO_FM, RATIO_AM, RATIO_TOD};

  logic [NUM_TAPS-1:0] tap;

  refdiv_prescale #(.DIV(RATIO[TAP_CTRL])) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tap[TAP_CTRL]),
    .sq   (ctrl_sq)
  );

  for (genvar i = 1; i < NUM_TAPS; i++) begin : g_stage
    refdiv_stage #(.DIV(RATIO[i])) u_stage (
      .clk    (clk),
      .rst    (rst),
      .en_in  (tap[i-1]),
      .en_out (tap[i])
    );
  end

  refdiv_refsel u_sel (
    .clk         (clk),
    .rst         (rst),
    .band_sel    (band_sel),
    .tick_fm     (tap[TAP_FM]),
    .tick_am     (tap[TAP_AM]),
    .ref_tick    (ref_tick),
    .band_active (band_active)
  );

  assign tick_ctrl = tap[TAP_CTRL];
  assign tick_fm   = tap[TAP_FM];
  assign tick_am   = tap[TAP_AM];
  assign tick_tod  = tap[TAP_TOD];

  AST_TOD_NESTED: assert property (@(posedge clk) disable iff (rst)
    tick_tod |-> tick_am); // R6
  AST_AM_ON_FM: assert property (@(posedge clk) disable iff (rst)
    tick_am |-> tick_fm); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (tap == '0 && ctrl_sq)); // R1
endmodule

// File: tb/refdiv_top_bench.sv
module refdiv_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic band_sel = 1'b1;
  logic ctrl_sq, tick_ctrl, tick_fm, tick_am, tick_tod, ref_tick, band_active;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int k = 0;
  bit band_m = 1'b1;
  bit started = 1'b0;
  bit after_mid = 1'b0;

  always #2 clk = ~clk;

  refdiv_top u_refdiv_top (
    .clk         (clk),
    .rst         (rst),
    .band_sel    (band_sel),
    .ctrl_sq     (ctrl_sq),
    .tick_ctrl   (tick_ctrl),
    .tick_fm     (tick_fm),
    .tick_am     (tick_am),
    .tick_tod    (tick_tod),
    .ref_tick    (ref_tick),
    .band_active (band_active)
  );

  // Behavioural reference: k counts edges since reset release
  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      k = 0;
      band_m = band_sel;
    end else begin
      if (k % 8000 == 7999) band_m = band_sel;
      k = k + 1;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s k=%0d actual=%0b expected=%0b", tag, k, act, exp);
    end
  endtask

  function automatic string tg(input string dflt);
    if (rst) return "R1";
    if (after_mid && k < 320) return {"R9/", dflt};
    return dflt;
  endfunction

  always @(negedge clk) begin
    if (started && !done) begin
      chk(tg("R2 tick_ctrl"), tick_ctrl, (k % 8) == 7);
      chk(tg("R3 ctrl_sq"),   ctrl_sq,   (k % 8) < 4);
      chk(tg("R4 tick_fm"),   tick_fm,   (k % 320) == 319);
      chk(tg("R5 tick_am"),   tick_am,   (k % 8000) == 7999);
      chk(tg("R6 tick_tod"),  tick_tod,  (k % 80000) == 79999);
      chk(tg("R7 ref_tick"),  ref_tick,
          band_m ? ((k % 320) == 319) : ((k % 8000) == 7999));
      chk(tg("R8 band_active"), band_active, band_m);
    end
  end

  task automatic wait_k(input int target);
    while (k != target) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: request AM early in a period; must wait for the boundary
    wait_k(1000);  band_sel = 1'b0;
    // R8: short FM pulse that is withdrawn before the boundary
    wait_k(9000);  band_sel = 1'b1;
    wait_k(9500);  band_sel = 1'b0;
    // R8: FM request applied at the 24000 boundary
    wait_k(17000); band_sel = 1'b1;
    // R8: change on the cycle just before a boundary
    wait_k(31999); band_sel = 1'b0;
    wait_k(40100); band_sel = 1'b1;
    wait_k(47999); band_sel = 1'b0;
    wait_k(48001); band_sel = 1'b1;
    // R6: run past two time-of-day periods
    wait_k(161003);
    // R9: reset in mid-run at an odd phase
    rst = 1'b1;
    band_sel = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    after_mid = 1'b1;
    repeat (700) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    @(negedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog k=%0d actual=running expected=finished", k);
    finish_run();
  end
endmodule